// File: doc/BRIEF.md
# Packed-Lane Integer ALU

This block is a 64-bit integer datapath that views its two operands either as a single 64-bit value or as a row of independent narrow lanes of 8, 16 or 32 bits. One opcode is applied to every lane at once. Each lane result is placed in the same bit positions as its inputs.

Arithmetic can wrap modulo the lane size or clamp at the lane's limits. A mode flag picks whether lanes hold signed two's-complement numbers or unsigned numbers.

The operation set covers several groups:
- add and subtract;
- minimum and maximum;
- absolute value and rounding average;
- five bitwise functions;
- six lane compares that return masks;
- a sum of absolute differences that folds every lane into one scalar.

Operands are presented together with a valid strobe. The chosen result is captured into an output register one clock later.

Top module: `simd_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W +: W]. No carry or borrow passes from one lane into the next.
- R2: With `sat_mode`=0, add (op 0) returns (a+b) mod 2^W per lane and subtract (op 1) returns (a-b) mod 2^W per lane.
- R3: With `sat_mode`=1 and `signed_mode`=1, add and subtract clamp to the limits of the lane when the true result is out of range. The upper limit is 2^(W-1)-1 and the lower limit is -2^(W-1).
- R4: With `sat_mode`=1 and `signed_mode`=0, an add that exceeds 2^W-1 returns all-ones. A subtract that would go below zero returns zero.
- R5: Min (op 2) and max (op 3) return the smaller or the larger lane value. The comparison is signed or unsigned according to `signed_mode`.
- R6: Abs (op 4) returns the magnitude of operand a per lane when `signed_mode`=1 and returns a unchanged when `signed_mode`=0. In the signed case the most negative value stays unchanged when `sat_mode`=0 and becomes 2^(W-1)-1 when `sat_mode`=1.
- R7: Average (op 5) returns floor((a+b+1)/2) per lane, computed without overflow. `sat_mode` has no effect on it.
- R8: The bitwise functions are and (op 6), or (op 7), xor (op 8), invert a (op 9) and a-and-not-b (op 10). They give the same result for any `signed_mode` and `sat_mode`.
- R9: The compares are equal (op 11), not-equal (op 12), greater (op 13), greater-or-equal (op 14), less (op 15) and less-or-equal (op 16). Each writes all-ones into a lane where a relates to b as named and all-zeros elsewhere. Ordering is signed or unsigned per `signed_mode`.
- R10: Op 17 returns the sum over all lanes of |a-b|, taken in the signed or unsigned sense of `signed_mode`, zero-extended to 64 bits.
- R11: The result and `out_valid` appear one clock after `in_valid` is high. `out_valid` is low one clock after `in_valid` is low, and the result register then keeps its previous value.
- R12: A synchronous active-high `rst` clears `out_valid` and the result register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b |
| op | input | 5 | Operation code (0 to 17) |
| lane_sz | input | 2 | Lane width select |
| signed_mode | input | 1 | 1: lanes are signed, 0: unsigned |
| sat_mode | input | 1 | 1: clamp, 0: wrap |
| out_valid | output | 1 | Registered result is new |
| out_result | output | 64 | Registered result |

## Verification
The bench applies a grid of 8-bit operands clustered at zero, at the signed midpoint and at all-ones. This catches a clamp that picks the wrong limit, and an unsigned borrow that wraps instead of giving zero. The most negative value is driven into abs in both modes; a design that negates it blindly returns the wrong value under saturation. The average grid reaches 255+255 and -128+-128, where a sum without an extra bit would lose the carry and return a value near half range. Wider lane sizes receive mixes of boundary and random lanes, which expose a carry leaking across a lane edge. The sum of absolute differences is checked against an arithmetic total, which exposes a lane summed in the wrong signedness.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_MIN  = 5'd2,
    OP_MAX  = 5'd3,
    OP_ABS  = 5'd4,
    OP_AVG  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_NOT  = 5'd9,
    OP_ANDN = 5'd10,
    OP_EQ   = 5'd11,
    OP_NE   = 5'd12,
    OP_GT   = 5'd13,
    OP_GE   = 5'd14,
    OP_LT   = 5'd15,
    OP_LE   = 5'd16,
    OP_SAD  = 5'd17
  } op_e;

  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE_W = 8;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int LW = 8
) (
  input  logic [LW-1:0]    a_i,
  input  logic [LW-1:0]    b_i,
  input  simd_pkg::op_e    op_i,
  input  logic             sgn_i,
  input  logic             sat_i,
  output logic [LW-1:0]    y_o,
  output logic [LW-1:0]    absd_o
);
  import simd_pkg::*;

  localparam int XW = LW + 1;

  logic [XW-1:0] xa, xb, add_x, sub_x;
  logic [LW-1:0] top_v, bot_v, neg_a, avg_v;
  logic          a_lt_b, a_eq_b, add_ovf, sub_ovf;

  always_comb begin
    // one extension bit: sign copy when signed, zero when unsigned
    xa      = {sgn_i & a_i[LW-1], a_i};
    xb      = {sgn_i & b_i[LW-1], b_i};
    add_x   = xa + xb;
    sub_x   = xa - xb;
    // the extended difference never overflows, so its top bit is the ordering
    a_lt_b  = sub_x[LW];
    a_eq_b  = (a_i == b_i);
    top_v   = sgn_i ? {1'b0, {(LW-1){1'b1}}} : {LW{1'b1}};
    bot_v   = sgn_i ? {1'b1, {(LW-1){1'b0}}} : {LW{1'b0}};
    add_ovf = sgn_i ? (add_x[LW] ^ add_x[LW-1]) : add_x[LW];
    sub_ovf = sgn_i ? (sub_x[LW] ^ sub_x[LW-1]) : sub_x[LW];
    neg_a   = LW'(0) - a_i;
    avg_v   = add_x[LW:1] + LW'(add_x[0]);
    absd_o  = sub_x[LW] ? (LW'(0) - sub_x[LW-1:0]) : sub_x[LW-1:0];

    y_o = '0;
    case (op_i)
      OP_ADD:  y_o = (sat_i && add_ovf) ? ((sgn_i && add_x[LW]) ? bot_v : top_v)
                                        : add_x[LW-1:0];
      OP_SUB:  y_o = (sat_i && sub_ovf) ? ((sgn_i && !sub_x[LW]) ? top_v : bot_v)
                                        : sub_x[LW-1:0];
      OP_MIN:  y_o = a_lt_b ? a_i : b_i;
      OP_MAX:  y_o = a_lt_b ? b_i : a_i;
      OP_ABS:  y_o = (sgn_i && a_i[LW-1]) ? ((sat_i && a_i == bot_v) ? top_v : neg_a)
                                          : a_i;
      OP_AVG:  y_o = avg_v;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NOT:  y_o = ~a_i;
      OP_ANDN: y_o = a_i & ~b_i;
      OP_EQ:   y_o = {LW{a_eq_b}};
      OP_NE:   y_o = {LW{!a_eq_b}};
      OP_GT:   y_o = {LW{!a_lt_b && !a_eq_b}};
      OP_GE:   y_o = {LW{!a_lt_b}};
      OP_LT:   y_o = {LW{a_lt_b}};
      OP_LE:   y_o = {LW{a_lt_b || a_eq_b}};
      default: y_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_ADD && sat_i && !sgn_i) begin
      // R4
      usat_add_no_wrap_chk: assert (y_o >= a_i && y_o >= b_i);
    end
    if (op_i == OP_SUB && sat_i && !sgn_i) begin
      // R4
      usat_sub_no_wrap_chk: assert (y_o <= a_i);
    end
    if (op_i == OP_AVG && !sgn_i) begin
      // R7
      avg_between_chk: assert (y_o >= (a_i < b_i ? a_i : b_i) && y_o <= (a_i < b_i ? b_i : a_i));
    end
    if (op_i inside {OP_EQ, OP_NE, OP_GT, OP_GE, OP_LT, OP_LE}) begin
      // R9
      cmp_mask_chk: assert (y_o == '0 || y_o == '1);
    end
  end
endmodule

// File: rtl/simd_sad_reduce.sv
module simd_sad_reduce #(
  parameter int DATA_W = 64,
  parameter int LW     = 8
) (
  input  logic [DATA_W-1:0] absd_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int NL = DATA_W / LW;

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NL; i++) begin
      sum_o = sum_o + DATA_W'(absd_i[i*LW +: LW]);
    end
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [4:0]        op,
  input  logic [1:0]        lane_sz,
  input  logic              signed_mode,
  input  logic              sat_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  import simd_pkg::*;

  localparam int NSZ = NUM_SIZES;

  op_e               op_q;
  logic [DATA_W-1:0] lane_y   [NSZ];
  logic [DATA_W-1:0] lane_sad [NSZ];
  logic [DATA_W-1:0] result_d;

  assign op_q = op_e'(op);

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int LW = MIN_LANE_W << k;
    localparam int NL = DATA_W / LW;
    logic [DATA_W-1:0] y_k, d_k;

    for (genvar j = 0; j < NL; j++) begin : g_ln
      simd_lane_alu #(.LW(LW)) u_lane (
        .a_i    (opa[j*LW +: LW]),
        .b_i    (opb[j*LW +: LW]),
        .op_i   (op_q),
        .sgn_i  (signed_mode),
        .sat_i  (sat_mode),
        .y_o    (y_k[j*LW +: LW]),
        .absd_o (d_k[j*LW +: LW])
      );
    end

    simd_sad_reduce #(.DATA_W(DATA_W), .LW(LW)) u_sad (
      .absd_i (d_k),
      .sum_o  (lane_sad[k])
    );

    assign lane_y[k] = y_k;
  end

  assign result_d = (op_q == OP_SAD) ? lane_sad[lane_sz] : lane_y[lane_sz];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= result_d;
    end
  end

  // R11
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_result));
endmodule

// File: tb/sim_simd_alu.sv
module sim_simd_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [4:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic        signed_mode = 1'b0, sat_mode = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  simd_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .op(op), .lane_sz(lane_sz), .signed_mode(signed_mode), .sat_mode(sat_mode),
    .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(int o, bit sg, bit st);
    if (o <= 1) return st ? (sg ? "R3" : "R4") : "R2";
    if (o <= 3) return "R5";
    if (o == 4) return "R6";
    if (o == 5) return "R7";
    if (o <= 10) return "R8";
    if (o <= 16) return "R9";
    return "R10";
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, int o,
                                        int sz, bit sg, bit st);
    int w, n;
    logic [63:0] msk, res, sad, la, lb, lane;
    logic signed [67:0] m, va, vb, r, lo, hi, d;
    w = 8 << sz;
    n = 64 / w;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    m = 68'sd1 <<< w;
    lo = sg ? -(m >>> 1) : 68'sd0;
    hi = sg ? (m >>> 1) - 68'sd1 : m - 68'sd1;
    res = '0;
    sad = '0;
    for (int i = 0; i < n; i++) begin
      la = (a >> (i*w)) & msk;
      lb = (b >> (i*w)) & msk;
      va = $signed({4'b0, la});
      vb = $signed({4'b0, lb});
      if (sg && la[w-1]) va = va - m;
      if (sg && lb[w-1]) vb = vb - m;
      case (o)
        0: r = va + vb;
        1: r = va - vb;
        2: r = (va < vb) ? va : vb;
        3: r = (va > vb) ? va : vb;
        4: r = (va < 0) ? -va : va;
        5: r = (va + vb + 68'sd1) >>> 1;
        6: r = $signed({4'b0, la & lb});
        7: r = $signed({4'b0, la | lb});
        8: r = $signed({4'b0, la ^ lb});
        9: r = $signed({4'b0, ~la});
        10: r = $signed({4'b0, la & ~lb});
        11: r = (va == vb) ? -68'sd1 : 68'sd0;
        12: r = (va != vb) ? -68'sd1 : 68'sd0;
        13: r = (va > vb) ? -68'sd1 : 68'sd0;
        14: r = (va >= vb) ? -68'sd1 : 68'sd0;
        15: r = (va < vb) ? -68'sd1 : 68'sd0;
        default: r = (va <= vb) ? -68'sd1 : 68'sd0;
      endcase
      if (st && (o == 0 || o == 1 || o == 4)) begin
        if (r > hi) r = hi;
        if (r < lo) r = lo;
      end
      lane = r[63:0] & msk;
      res = res | (lane << (i*w));
      d = va - vb;
      if (d < 0) d = -d;
      sad = sad + d[63:0];
    end
    return (o == 17) ? sad : res;
  endfunction

  function automatic logic [63:0] pick(int w);
    logic [63:0] msk;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    case ($urandom % 6)
      0: return 64'd0;
      1: return msk;
      2: return 64'd1 << (w - 1);
      3: return msk >> 1;
      4: return 64'd1;
      default: return {$urandom, $urandom} & msk;
    endcase
  endfunction

  function automatic logic [7:0] grid(int k);
    if (k < 8) return 8'(k);
    if (k < 24) return 8'(112 + k);
    return 8'(224 + k);
  endfunction

  task automatic run_vec(input logic [63:0] a, input logic [63:0] b, input int o,
                         input int sz, input bit sg, input bit st);
    logic [63:0] exp;
    @(negedge clk);
    opa = a; opb = b; op = 5'(o); lane_sz = 2'(sz);
    signed_mode = sg; sat_mode = st; in_valid = 1'b1;
    @(posedge clk);
    #2;
    exp = model(a, b, o, sz, sg, st);
    check(out_valid && out_result == exp, req_of(o, sg, st), out_result, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b, held;
    // R12: reset state, with garbage on the inputs
    in_valid = 1'b1; opa = '1; opb = 64'h1234; op = 5'd0;
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && out_result == '0, "R12", out_result, 64'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;

    // R1: a carry out of each byte must not reach the next byte
    run_vec(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 0, 0, 0);
    check(out_result == 64'h0, "R1", out_result, 64'h0);
    // R1: a borrow out of each 16-bit lane must not reach the next lane
    run_vec(64'h0, 64'h0001_0001_0001_0001, 1, 1, 0, 0);
    check(out_result == '1, "R1", out_result, '1);
    // R1: 32-bit lane add, carry held inside the lower lane
    run_vec(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2, 0, 0);
    check(out_result == 64'h0, "R1", out_result, 64'h0);

    // 8-bit grid: 32 x 32 operand pairs, 8 pairs per vector
    for (int o = 0; o < 18; o++) begin
      for (int md = 0; md < 4; md++) begin
        for (int v = 0; v < 128; v++) begin
          a = '0; b = '0;
          for (int j = 0; j < 8; j++) begin
            a[j*8 +: 8] = grid((v*8 + j) >> 5);
            b[j*8 +: 8] = grid((v*8 + j) & 31);
          end
          run_vec(a, b, o, 0, md[1], md[0]);
        end
      end
    end

    // wider lanes: boundary and random lane values
    for (int sz = 1; sz < 4; sz++) begin
      for (int o = 0; o < 18; o++) begin
        for (int md = 0; md < 4; md++) begin
          for (int v = 0; v < 48; v++) begin
            a = '0; b = '0;
            for (int j = 0; j < (64 >> (sz + 3)); j++) begin
              a = a | (pick(8 << sz) << (j * (8 << sz)));
              b = b | (pick(8 << sz) << (j * (8 << sz)));
            end
            run_vec(a, b, o, sz, md[1], md[0]);
          end
        end
      end
    end

    // R11: with in_valid low the result holds and out_valid drops
    run_vec(64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111, 0, 0, 0, 0);
    held = out_result;
    @(negedge clk);
    in_valid = 1'b0; opa = '1; opb = '1; op = 5'd8;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #2;
      check(!out_valid && out_result == held, "R11", out_result, held);
    end

    // R12: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk);
    #2;
    check(!out_valid && out_result == '0, "R12", out_result, 64'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule